// File: doc/BRIEF.md
# Speculative Load Disambiguation Unit

This block keeps the memory operations of an out-of-order core in program order inside a small circular ordering buffer. It lets a load start before older stores whose addresses are still unknown. Each entry is allocated in order and gets a slot tag. Store addresses arrive later from address generation, through the resolve port. A load asks to execute on the issue port. If an older store is still unresolved, the grant depends on a learned alias predictor that is indexed by part of the load's program counter.

When a store address resolves, the block compares the full address with every younger load that has already executed. A matching load is flagged for replay. Replays leave the block one per cycle, oldest first. Each replay trains the predictor against bypassing for that load and starts a fixed stall window, during which no load is granted. Entries leave from the head when the retire input is asserted and the head entry is allowed to complete. When a load that bypassed retires without a conflict, its predictor counter drops by one.

Top module: `mem_order_guard`

## Requirements
- R1: After a synchronous active-low reset the buffer is empty: alloc_ready is 1, retire_ready is 0, replay_valid is 0 and busy is 0. All predictor counters are 0, so bypass is allowed.
- R2: Allocation accepts one entry per cycle while fewer than DEPTH entries are held. alloc_tag gives the slot used, and the slots follow one another modulo DEPTH. alloc_ready is 0 when DEPTH entries are held.
- R3: A valid, unexecuted load that is not waiting for replay is granted whenever busy is 0 and every older store in the buffer has a resolved address. The predictor is not consulted in that case.
- R4: A load with at least one older unresolved store is granted only if the 2-bit counter selected by PC bits [5:2] holds a value below 2.
- R5: When a store address resolves, any younger load that has executed, or is granted in the same cycle, with an equal address is flagged. Loads older than the store are never flagged. replay_valid is 1 with replay_tag naming the load in the cycle after the flag. The replayed load must then be issued again.
- R6: When several loads are flagged, one replay is raised per cycle, always for the oldest flagged load.
- R7: Each replay sets the counter for that load's PC bits [5:2] to 3, and train_valid/train_index report that index in the same cycle. When a load that was granted past an unresolved store retires, its counter drops by one, saturating at 0. Training wins when both act on the same counter in the same cycle.
- R8: busy rises in the same cycle as replay_valid and stays high for exactly 20 cycles after the last replay. No load is granted while busy is 1.
- R9: retire_ready is 1 only for a valid head entry that is either a resolved store or an executed load not waiting for replay. A load therefore never retires while an older store is unresolved. A retire request when retire_ready is 0 is ignored.
- R10: Conflict detection compares all address bits. Addresses that differ only in bit 31 never cause a replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate an entry at the tail |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_pc | input | 32 | Program counter of the allocated operation |
| alloc_ready | output | 1 | Buffer has a free slot |
| alloc_tag | output | 3 | Slot that the allocation takes |
| resolve_valid | input | 1 | A store address is delivered |
| resolve_tag | input | 3 | Slot of the store |
| resolve_addr | input | 32 | Resolved store address |
| issue_req | input | 1 | A load asks to execute |
| issue_tag | input | 3 | Slot of the load |
| issue_addr | input | 32 | Load address |
| issue_grant | output | 1 | Load may execute this cycle |
| retire_valid | input | 1 | Retire the head entry if allowed |
| retire_ready | output | 1 | Head entry may retire |
| replay_valid | output | 1 | A load must be re-executed |
| replay_tag | output | 3 | Slot of the load to replay |
| train_valid | output | 1 | Predictor was trained toward no-bypass |
| train_index | output | 4 | Predictor index that was trained |
| busy | output | 1 | Replay penalty window in progress |

## Verification
The hardest state to reach is a single store resolve that catches several executed younger loads at once, mixed with loads older than the store and loads that differ only in the top address bit. This needs a run of bypass grants made while the store is unresolved. The bench builds this on purpose: several loads with fresh predictor indices are issued before the store resolves, so the oldest-first replay order and the full-address compare can be seen over consecutive cycles. A random phase with a four-value address pool and a few PC values then makes replay, training, decay and stalls overlap, and a bench model predicts every output on every cycle.

// File: rtl/mog_pkg.sv
// Shared types for the load disambiguation unit.
// Assumes: predictor counters are 2-bit saturating values.
package mog_pkg;
    localparam int CTR_W = 2;
    typedef logic [CTR_W-1:0] ctr_t;
    localparam ctr_t CTR_TRAINED      = 2'd3;
    localparam ctr_t CTR_BYPASS_LIMIT = 2'd2;
endpackage

// File: rtl/mog_predictor.sv
// Alias predictor: a table of saturating counters, one per index.
// A lookup allows bypass when its counter is below the limit. Training
// sets a counter to the top value; decay lowers one by one.
// Assumes: training has priority over decay on the same counter.
module mog_predictor
    import mog_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lookup_idx,
    output logic             lookup_ok,
    input  logic             train_en,
    input  logic [IDX_W-1:0] train_idx,
    input  logic             dec_en,
    input  logic [IDX_W-1:0] dec_idx
);
    localparam int ENTRIES = 1 << IDX_W;

    ctr_t ctr_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ctr
        // Update one counter: train, decay or hold.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctr_q[e] <= '0;
            end else if (train_en && train_idx == IDX_W'(e)) begin
                ctr_q[e] <= CTR_TRAINED;
            end else if (dec_en && dec_idx == IDX_W'(e) && ctr_q[e] != '0) begin
                ctr_q[e] <= ctr_q[e] - 1'b1;
            end
        end
    end

    // Bypass permission for the load being looked up.
    always_comb lookup_ok = ctr_q[lookup_idx] < CTR_BYPASS_LIMIT;
endmodule

// File: rtl/mog_oldest_pick.sv
// Picks the oldest set bit of a slot mask in a circular buffer whose
// oldest slot is `base`.
// Assumes: DEPTH is a power of two, so slot arithmetic wraps.
module mog_oldest_pick #(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] mask,
    input  logic [TAG_W-1:0] base,
    output logic             found,
    output logic [TAG_W-1:0] slot
);
    // Walk ages from oldest to youngest and keep the first hit.
    always_comb begin
        found = 1'b0;
        slot  = '0;
        for (int r = 0; r < DEPTH; r++) begin
            if (!found && mask[base + TAG_W'(r)]) begin
                found = 1'b1;
                slot  = base + TAG_W'(r);
            end
        end
    end
endmodule

// File: rtl/mog_stall_timer.sv
// Replay penalty timer: busy for PENALTY cycles starting with the cycle
// in which a replay is reported. A new replay restarts the window.
module mog_stall_timer #(
    parameter int PENALTY = 20,
    localparam int CNT_W = $clog2(PENALTY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CNT_W-1:0] cnt_q;

    // Load on a replay, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (start)         cnt_q <= CNT_W'(PENALTY);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    // Busy while the window has cycles left.
    always_comb busy = cnt_q != '0;
endmodule

// File: rtl/mem_order_guard.sv
// Speculative load disambiguation unit. A circular ordering buffer of
// DEPTH entries holds stores and loads in program order. Loads may
// execute past unresolved older stores when the alias predictor allows
// it. Resolving stores scan younger executed loads for equal addresses
// and flag them for replay, oldest first, one per cycle.
// Assumes: DEPTH is a power of two. Tags presented on the resolve and
// issue ports name live entries. Each store resolves once.
module mem_order_guard #(
    parameter int DEPTH   = 8,
    parameter int ADDR_W  = 32,
    parameter int PC_W    = 32,
    parameter int IDX_W   = 4,
    parameter int IDX_LSB = 2,
    parameter int PENALTY = 20,
    localparam int TAG_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic              alloc_is_store,
    input  logic [PC_W-1:0]   alloc_pc,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              resolve_valid,
    input  logic [TAG_W-1:0]  resolve_tag,
    input  logic [ADDR_W-1:0] resolve_addr,
    input  logic              issue_req,
    input  logic [TAG_W-1:0]  issue_tag,
    input  logic [ADDR_W-1:0] issue_addr,
    output logic              issue_grant,
    input  logic              retire_valid,
    output logic              retire_ready,
    output logic              replay_valid,
    output logic [TAG_W-1:0]  replay_tag,
    output logic              train_valid,
    output logic [IDX_W-1:0]  train_index,
    output logic              busy
);
    localparam int CNT_W = TAG_W + 1;

    // Per-entry state, one bit per slot.
    logic [DEPTH-1:0]  ent_v, ent_st, ent_res, ent_ex, ent_pd, ent_spec;
    logic [ADDR_W-1:0] ent_addr [DEPTH];
    logic [IDX_W-1:0]  ent_pc   [DEPTH];

    logic [TAG_W-1:0]  head_q, tail_q;
    logic [CNT_W-1:0]  count_q;

    logic              alloc_fire, retire_fire, resolve_ok;
    logic              older_unres, pred_ok, issue_base;
    logic [DEPTH-1:0]  conf, cand;
    logic              rep_any;
    logic [TAG_W-1:0]  rep_idx;
    logic              dec_en;

    logic              replay_valid_q, train_valid_q;
    logic [TAG_W-1:0]  replay_tag_q;
    logic [IDX_W-1:0]  train_idx_q;

    // Age of a slot relative to the head; smaller is older.
    function automatic logic [TAG_W-1:0] age_of(input logic [TAG_W-1:0] s);
        return s - head_q;
    endfunction

    // Allocation and retirement handshakes.
    always_comb begin
        alloc_ready  = count_q != CNT_W'(DEPTH);
        alloc_tag    = tail_q;
        alloc_fire   = alloc_valid && alloc_ready;
        retire_ready = ent_v[head_q] &&
                       (ent_st[head_q] ? ent_res[head_q]
                                       : (ent_ex[head_q] && !ent_pd[head_q]));
        retire_fire  = retire_valid && retire_ready;
        dec_en       = retire_fire && !ent_st[head_q] && ent_spec[head_q];
    end

    // Detect any older store whose address is still unknown.
    always_comb begin
        older_unres = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
            if (ent_v[j] && ent_st[j] && !ent_res[j] &&
                age_of(TAG_W'(j)) < age_of(issue_tag))
                older_unres = 1'b1;
        end
    end

    // Issue decision: ordered loads go freely, bypassing needs the predictor.
    always_comb begin
        issue_base  = issue_req && ent_v[issue_tag] && !ent_st[issue_tag] &&
                      !ent_ex[issue_tag] && !ent_pd[issue_tag] && !busy;
        issue_grant = issue_base && (!older_unres || pred_ok);
    end

    // Conflict scan of younger executed loads against a resolving store.
    always_comb begin
        logic             live;
        logic [ADDR_W-1:0] la;
        resolve_ok = resolve_valid && ent_v[resolve_tag] &&
                     ent_st[resolve_tag] && !ent_res[resolve_tag];
        conf = '0;
        for (int j = 0; j < DEPTH; j++) begin
            live = ent_ex[j] || (issue_grant && issue_tag == TAG_W'(j));
            la   = (issue_grant && issue_tag == TAG_W'(j)) ? issue_addr : ent_addr[j];
            if (resolve_ok && ent_v[j] && !ent_st[j] && live &&
                age_of(TAG_W'(j)) > age_of(resolve_tag) && la == resolve_addr)
                conf[j] = 1'b1;
        end
        cand = ent_pd | conf;
    end

    mog_oldest_pick #(.DEPTH(DEPTH)) u_pick (
        .mask  (cand),
        .base  (head_q),
        .found (rep_any),
        .slot  (rep_idx)
    );

    mog_predictor #(.IDX_W(IDX_W)) u_pred (
        .clk        (clk),
        .rst_n      (rst_n),
        .lookup_idx (ent_pc[issue_tag]),
        .lookup_ok  (pred_ok),
        .train_en   (rep_any),
        .train_idx  (ent_pc[rep_idx]),
        .dec_en     (dec_en),
        .dec_idx    (ent_pc[head_q])
    );

    mog_stall_timer #(.PENALTY(PENALTY)) u_stall (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rep_any),
        .busy  (busy)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic do_alloc, do_ret, do_res, do_grant, do_rep;
        always_comb begin
            do_alloc = alloc_fire  && tail_q      == TAG_W'(i);
            do_ret   = retire_fire && head_q      == TAG_W'(i);
            do_res   = resolve_ok  && resolve_tag == TAG_W'(i);
            do_grant = issue_grant && issue_tag   == TAG_W'(i);
            do_rep   = rep_any     && rep_idx     == TAG_W'(i);
        end

        // Entry lifecycle: allocate, resolve, execute, replay, free.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_v[i]    <= 1'b0;
                ent_st[i]   <= 1'b0;
                ent_res[i]  <= 1'b0;
                ent_ex[i]   <= 1'b0;
                ent_pd[i]   <= 1'b0;
                ent_spec[i] <= 1'b0;
                ent_addr[i] <= '0;
                ent_pc[i]   <= '0;
            end else if (do_alloc) begin
                ent_v[i]    <= 1'b1;
                ent_st[i]   <= alloc_is_store;
                ent_res[i]  <= 1'b0;
                ent_ex[i]   <= 1'b0;
                ent_pd[i]   <= 1'b0;
                ent_spec[i] <= 1'b0;
                ent_pc[i]   <= alloc_pc[IDX_LSB +: IDX_W];
            end else if (do_ret) begin
                ent_v[i]    <= 1'b0;
                ent_pd[i]   <= 1'b0;
            end else begin
                if (do_res) ent_res[i] <= 1'b1;
                if (do_grant) begin
                    ent_ex[i]   <= 1'b1;
                    ent_addr[i] <= issue_addr;
                    ent_spec[i] <= older_unres;
                end
                ent_pd[i] <= cand[i] && !do_rep;
                if (do_rep) begin
                    ent_ex[i]   <= 1'b0;
                    ent_spec[i] <= 1'b0;
                end
            end
        end
    end

    // Head, tail and occupancy bookkeeping of the circular buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (alloc_fire)  tail_q <= tail_q + 1'b1;
            if (retire_fire) head_q <= head_q + 1'b1;
            count_q <= count_q + CNT_W'(alloc_fire) - CNT_W'(retire_fire);
        end
    end

    // Registered replay and training report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            replay_valid_q <= 1'b0;
            replay_tag_q   <= '0;
            train_valid_q  <= 1'b0;
            train_idx_q    <= '0;
        end else begin
            replay_valid_q <= rep_any;
            replay_tag_q   <= rep_idx;
            train_valid_q  <= rep_any;
            train_idx_q    <= ent_pc[rep_idx];
        end
    end

    // Drive the report ports.
    always_comb begin
        replay_valid = replay_valid_q;
        replay_tag   = replay_tag_q;
        train_valid  = train_valid_q;
        train_index  = train_idx_q;
    end
endmodule

// File: rtl/mog_checker.sv
// Temporal checks for mem_order_guard, bound into every instance.
// Assumes: ent_v and ent_st are the top's slot-valid and is-store bits.
module mog_checker #(
    parameter int DEPTH   = 8,
    parameter int PENALTY = 20,
    localparam int TAG_W  = $clog2(DEPTH),
    localparam int SW     = $clog2(PENALTY + 2)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_ready,
    input logic             retire_ready,
    input logic             replay_valid,
    input logic [TAG_W-1:0] replay_tag,
    input logic             issue_grant,
    input logic             busy,
    input logic [DEPTH-1:0] ent_v,
    input logic [DEPTH-1:0] ent_st,
    input logic [TAG_W-1:0] head_q
);
    logic [SW-1:0] since_q;

    // Count cycles since the last reported replay, saturating past the window.
    always_ff @(posedge clk) begin
        if (!rst_n)                             since_q <= '0;
        else if (replay_valid)                  since_q <= SW'(1);
        else if (since_q != '0 && since_q <= SW'(PENALTY)) since_q <= since_q + 1'b1;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (alloc_ready && !retire_ready && !replay_valid && !busy));

    a_r8_busy_on_replay: assert property (@(posedge clk) disable iff (!rst_n)
        replay_valid |-> busy);

    a_r8_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q != '0 && since_q < SW'(PENALTY)) |-> busy);

    a_r8_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == SW'(PENALTY) && !replay_valid) |-> !busy);

    a_r8_no_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !issue_grant);

    a_r5_replay_is_load: assert property (@(posedge clk) disable iff (!rst_n)
        replay_valid |-> (ent_v[replay_tag] && !ent_st[replay_tag]));

    a_r9_retire_head_valid: assert property (@(posedge clk) disable iff (!rst_n)
        retire_ready |-> ent_v[head_q]);
endmodule

bind mem_order_guard mog_checker #(.DEPTH(DEPTH), .PENALTY(PENALTY)) u_mog_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_ready  (alloc_ready),
    .retire_ready (retire_ready),
    .replay_valid (replay_valid),
    .replay_tag   (replay_tag),
    .issue_grant  (issue_grant),
    .busy         (busy),
    .ent_v        (ent_v),
    .ent_st       (ent_st),
    .head_q       (head_q)
);

// File: tb/test_mem_order_guard.sv
`timescale 1ns/1ps
// Bench: directed corner cases, then seeded random traffic, all checked
// every cycle against a bench model written from the requirements.
module test_mem_order_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_v = 0, a_st = 0;
    logic [31:0] a_pc = 0;
    logic        r_v = 0;
    logic [2:0]  r_tag = 0;
    logic [31:0] r_addr = 0;
    logic        i_req = 0;
    logic [2:0]  i_tag = 0;
    logic [31:0] i_addr = 0;
    logic        rt_v = 0;
    logic        alloc_ready, issue_grant, retire_ready, replay_valid, train_valid, busy;
    logic [2:0]  alloc_tag, replay_tag;
    logic [3:0]  train_index;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    bit s_grant;

    always #2.5 clk = ~clk;

    mem_order_guard i_mem_order_guard (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(a_v), .alloc_is_store(a_st), .alloc_pc(a_pc),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .resolve_valid(r_v), .resolve_tag(r_tag), .resolve_addr(r_addr),
        .issue_req(i_req), .issue_tag(i_tag), .issue_addr(i_addr),
        .issue_grant(issue_grant),
        .retire_valid(rt_v), .retire_ready(retire_ready),
        .replay_valid(replay_valid), .replay_tag(replay_tag),
        .train_valid(train_valid), .train_index(train_index), .busy(busy)
    );

    // Bench model of the buffer.
    bit m_v[8], m_st[8], m_res[8], m_ex[8], m_pd[8], m_sp[8];
    logic [31:0] m_ad[8];
    int m_pc[8], m_ctr[16];
    int m_head, m_tail, m_cnt, m_busy, m_rt, m_ti;
    bit m_rv;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int age(input int s);
        return (s - m_head) & 7;
    endfunction

    function automatic bit m_older_unres(input int t);
        for (int j = 0; j < 8; j++)
            if (m_v[j] && m_st[j] && !m_res[j] && age(j) < age(t)) return 1;
        return 0;
    endfunction

    function automatic bit m_grant();
        int t = int'(i_tag);
        if (!(i_req && m_v[t] && !m_st[t] && !m_ex[t] && !m_pd[t] && m_busy == 0)) return 0;
        return !m_older_unres(t) || (m_ctr[m_pc[t]] < 2);
    endfunction

    function automatic bit m_ret_ok();
        int h = m_head;
        if (!m_v[h]) return 0;
        return m_st[h] ? m_res[h] : (m_ex[h] && !m_pd[h]);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_v[i] = 0; m_st[i] = 0; m_res[i] = 0; m_ex[i] = 0; m_pd[i] = 0; m_sp[i] = 0;
            m_ad[i] = 0; m_pc[i] = 0;
        end
        for (int i = 0; i < 16; i++) m_ctr[i] = 0;
        m_head = 0; m_tail = 0; m_cnt = 0; m_busy = 0; m_rv = 0; m_rt = 0; m_ti = 0;
    endtask

    // Next model state from the current state and inputs.
    task automatic model_advance();
        bit g, ou, rok, af, rf, any;
        bit cand[8];
        int pick, t, s, h;
        t = int'(i_tag); s = int'(r_tag); h = m_head;
        g   = m_grant();
        ou  = m_older_unres(t);
        rok = r_v && m_v[s] && m_st[s] && !m_res[s];
        af  = a_v && m_cnt < 8;
        rf  = rt_v && m_ret_ok();
        for (int j = 0; j < 8; j++) begin
            bit live = m_ex[j] || (g && t == j);
            logic [31:0] la = (g && t == j) ? i_addr : m_ad[j];
            cand[j] = m_pd[j] || (rok && m_v[j] && !m_st[j] && live &&
                                  age(j) > age(s) && la == r_addr);
        end
        any = 0; pick = 0;
        for (int r = 0; r < 8; r++)
            if (!any && cand[(h + r) & 7]) begin any = 1; pick = (h + r) & 7; end
        // predictor
        if (rf && !m_st[h] && m_sp[h] && !(any && m_pc[pick] == m_pc[h]) && m_ctr[m_pc[h]] > 0)
            m_ctr[m_pc[h]]--;
        if (any) m_ctr[m_pc[pick]] = 3;
        m_rv = any; m_rt = pick; m_ti = m_pc[pick];
        m_busy = any ? 20 : (m_busy > 0 ? m_busy - 1 : 0);
        // entries
        if (rok) m_res[s] = 1;
        if (g) begin m_ex[t] = 1; m_ad[t] = i_addr; m_sp[t] = ou; end
        for (int j = 0; j < 8; j++) m_pd[j] = cand[j] && !(any && pick == j);
        if (any) begin m_ex[pick] = 0; m_sp[pick] = 0; end
        if (rf) begin m_v[h] = 0; m_pd[h] = 0; m_head = (h + 1) & 7; end
        if (af) begin
            m_v[m_tail] = 1; m_st[m_tail] = a_st; m_res[m_tail] = 0; m_ex[m_tail] = 0;
            m_pd[m_tail] = 0; m_sp[m_tail] = 0; m_pc[m_tail] = int'(a_pc[5:2]);
            m_tail = (m_tail + 1) & 7;
        end
        m_cnt = m_cnt + int'(af) - int'(rf);
    endtask

    // One cycle: compare all outputs with the model, advance, land on negedge.
    task automatic step();
        #1;
        s_grant = issue_grant;
        check("R2 alloc_ready", alloc_ready, m_cnt < 8);
        check("R2 alloc_tag", alloc_tag, m_tail);
        check("R4 issue_grant", issue_grant, m_grant());
        check("R9 retire_ready", retire_ready, m_ret_ok());
        check("R5 replay_valid", replay_valid, m_rv);
        if (m_rv) check("R6 replay_tag", replay_tag, m_rt);
        check("R7 train_valid", train_valid, m_rv);
        if (m_rv) check("R7 train_index", train_index, m_ti);
        check("R8 busy", busy, m_busy != 0);
        model_advance();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        a_v = 0; r_v = 0; i_req = 0; rt_v = 0;
    endtask

    task automatic alloc(input bit st, input logic [31:0] pc);
        idle(); a_v = 1; a_st = st; a_pc = pc; step(); idle();
    endtask

    task automatic issue(input int t, input logic [31:0] ad);
        idle(); i_req = 1; i_tag = 3'(t); i_addr = ad; step(); idle();
    endtask

    task automatic resolve(input int t, input logic [31:0] ad);
        idle(); r_v = 1; r_tag = 3'(t); r_addr = ad; step(); idle();
    endtask

    task automatic retire();
        idle(); rt_v = 1; step(); idle();
    endtask

    task automatic wait_cycles(input int n);
        idle();
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1;
        // R1: reset state
        #1;
        check("R1 alloc_ready", alloc_ready, 1);
        check("R1 retire_ready", retire_ready, 0);
        check("R1 replay_valid", replay_valid, 0);
        check("R1 busy", busy, 0);
        @(negedge clk);

        // Scenario A: R4, R5, R10, R8, R7, R3, R9
        alloc(1, 32'h0);        // tag0 store
        alloc(0, 32'h4);        // tag1 load idx1
        alloc(0, 32'h8);        // tag2 load idx2
        alloc(1, 32'h0);        // tag3 store
        alloc(0, 32'h4);        // tag4 load idx1
        issue(1, 32'h10);
        check("R4 bypass with zero counter", s_grant, 1);
        issue(2, 32'h8000_0010);
        issue(4, 32'h10);
        check("R4 bypass past two stores", s_grant, 1);
        resolve(3, 32'h10);
        check("R5 younger load replayed", replay_valid, 1);
        check("R5 replay tag", replay_tag, 4);
        check("R8 busy with replay", busy, 1);
        check("R7 train index", train_index, 1);
        idle(); step();
        check("R5 single replay only", replay_valid, 0);
        resolve(0, 32'h10);
        check("R5 load behind oldest store", replay_tag, 1);
        idle(); step();
        check("R10 bit31 differs no replay", replay_valid, 0);
        issue(4, 32'h10);
        check("R8 no grant while busy", s_grant, 0);
        wait_cycles(20);
        check("R8 busy released", busy, 0);
        issue(4, 32'h10);
        check("R3 ordered load granted despite counter", s_grant, 1);
        issue(1, 32'h10);
        for (int k = 0; k < 5; k++) begin
            check("R9 head may retire", retire_ready, 1);
            retire();
        end
        check("R9 empty buffer cannot retire", retire_ready, 0);

        // Scenario B: R7 denial, R6 ordering (head now 5)
        alloc(1, 32'h0);        // tag5 store
        alloc(0, 32'h4);        // tag6 load idx1 (trained)
        alloc(0, 32'h30);       // tag7 idx12
        alloc(0, 32'h34);       // tag0 idx13
        issue(6, 32'h20);
        check("R7 trained counter denies bypass", s_grant, 0);
        issue(7, 32'h20);
        issue(0, 32'h20);
        rt_v = 1; step(); idle();
        check("R9 unresolved store blocks retire", retire_ready, 0);
        resolve(5, 32'h20);
        check("R6 oldest replay first", replay_tag, 7);
        idle(); step();
        check("R6 second replay", replay_valid, 1);
        check("R6 second replay tag", replay_tag, 0);
        wait_cycles(21);
        issue(6, 32'h20); issue(7, 32'h20); issue(0, 32'h20);
        for (int k = 0; k < 4; k++) retire();

        // Fill to full: R2
        for (int k = 0; k < 8; k++) alloc(1, 32'h0);
        check("R2 full buffer refuses", alloc_ready, 0);
        for (int k = 0; k < 8; k++) begin
            resolve((m_head + k) & 7, 32'h100);
        end
        for (int k = 0; k < 8; k++) retire();

        // Random phase
        for (int c = 0; c < 6000; c++) begin
            int st0;
            idle();
            a_v = ($urandom % 2) == 0; a_st = ($urandom % 5) < 2;
            a_pc = 32'(($urandom % 4) * 4);
            st0 = $urandom % 8;
            for (int k = 0; k < 8; k++) begin
                int j = (st0 + k) & 7;
                if (!r_v && m_v[j] && m_st[j] && !m_res[j] && ($urandom % 5) < 2) begin
                    r_v = 1; r_tag = 3'(j);
                    r_addr = 32'($urandom % 4) | (($urandom % 10) == 0 ? 32'h8000_0000 : 32'h0);
                end
            end
            st0 = $urandom % 8;
            for (int k = 0; k < 8; k++) begin
                int j = (st0 + k) & 7;
                if (!i_req && m_v[j] && !m_st[j] && !m_ex[j] && ($urandom % 2) == 0) begin
                    i_req = 1; i_tag = 3'(j);
                    i_addr = 32'($urandom % 4) | (($urandom % 10) == 0 ? 32'h8000_0000 : 32'h0);
                end
            end
            rt_v = ($urandom % 5) < 2;
            step();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule